// File: doc/BRIEF.md
# Segment Access Legality Checker

This block decides, one access at a time, whether a memory reference is allowed by the attributes, base and limit of the segment it goes through. It is handed the processor's mode flags (protection on, paging on, long mode active, code segment in long mode) and the segment's descriptor fields. It also receives the access address, byte count and kind: read, write or instruction fetch. From these it reports a general-protection fault, a request to send the access on to page translation, or a physical address equal to the incoming address.

Each access is presented with a one-cycle input strobe. The verdict comes out registered on the following clock edge, together with an output strobe. Checks apply only with protection on and outside 64-bit mode. Expand-up and expand-down segments are handled, and so are limits that sit numerically below the base (wrapped segments). Each of those four combinations has its own fault rule. The end of the access is computed one bit wider than the address, so a carry out of the top address bit is never lost.

Top module: `seg_access_check`

## Requirements
- R1: The outputs gp_fault, fault_code, xlate_req and phys_addr update on the clock edge that samples in_valid high. out_valid is high for exactly the cycle after each strobe and is low otherwise.
- R2: With prot_en low (real mode), no check is made. gp_fault and xlate_req are 0, and phys_addr equals acc_addr, whatever the segment fields are.
- R3: When lma and cs_long are both 1 (64-bit mode), no check is made and gp_fault is 0. If only one of the two is set, the checks apply.
- R4: With checks active, a write (acc_write=1) to a segment with seg_writable=0 faults. The same write to a writable segment does not fault.
- R5: With checks active, an access with acc_write=0 and acc_exec=0 to a segment with seg_readable=0 faults. A fetch (acc_exec=1) from that segment does not fault on this rule.
- R6: For an expand-up segment (seg_expdown=0) with limit >= base, the access faults when limit < addr+size.
- R7: For an expand-up segment with limit < base, the access faults only when limit < addr+size and addr < base both hold.
- R8: For an expand-down segment (seg_expdown=1) with limit < base, the access faults when addr <= limit, or when addr+size >= base.
- R9: For an expand-down segment with limit >= base, the access faults when addr <= limit and addr+size >= base both hold.
- R10: With prot_en=1, paging_en=1 and no fault, xlate_req is 1 and phys_addr is 0. With protection on, paging off and no fault, xlate_req is 0 and phys_addr equals acc_addr.
- R11: When gp_fault is 1, xlate_req is 0, phys_addr is 0 and fault_code is 0. fault_code is 0 in every result.
- R12: addr+size is evaluated with one extra bit. An access at 0xFFFFFFFE of 4 bytes against limit 0xFFFFFFFF faults, while a 1-byte access there does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Access strobe |
| prot_en | input | 1 | Protection enabled |
| paging_en | input | 1 | Paging enabled |
| lma | input | 1 | Long mode active |
| cs_long | input | 1 | Code segment is a 64-bit segment |
| seg_writable | input | 1 | Segment allows writes |
| seg_readable | input | 1 | Segment allows data reads |
| seg_expdown | input | 1 | Segment grows downward |
| seg_base | input | ADDR_W | Segment base |
| seg_limit | input | ADDR_W | Segment limit |
| acc_addr | input | ADDR_W | Access address |
| acc_size | input | SIZE_W | Access size in bytes |
| acc_write | input | 1 | Access is a write |
| acc_exec | input | 1 | Access is an instruction fetch |
| out_valid | output | 1 | Result strobe |
| gp_fault | output | 1 | General-protection fault |
| fault_code | output | CODE_W | Fault error code (always 0) |
| xlate_req | output | 1 | Forward access to page translation |
| phys_addr | output | ADDR_W | Physical address when not translated |

## Verification
The hardest cases to reach are those where the limit sits below the base. In those cases the expand-up and expand-down rules change from a conjunction to a disjunction, or the other way round. The other hard case is the carry out of addr+size past the top address bit. The stimulus builds wrapped segments directly: for example, base 0x8000 with limit 0x1000. It then places accesses on each side of both boundaries, so that every term of the fault rule is the only one deciding in at least one access. Last, it uses an all-ones limit with accesses whose end just crosses 2^32.

// File: rtl/seg_access_check.sv
module seg_access_check #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4,
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              prot_en,
  input  logic              paging_en,
  input  logic              lma,
  input  logic              cs_long,
  input  logic              seg_writable,
  input  logic              seg_readable,
  input  logic              seg_expdown,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              acc_write,
  input  logic              acc_exec,
  output logic              out_valid,
  output logic              gp_fault,
  output logic [CODE_W-1:0] fault_code,
  output logic              xlate_req,
  output logic [ADDR_W-1:0] phys_addr
);
  localparam int EW = ADDR_W + 1;

  logic          checks_on, perm_bad, wrapped, lim_bad, fault_n, xlate_n;
  logic [EW-1:0] acc_end, lim_x, base_x, addr_x;

  assign checks_on = prot_en & ~(lma & cs_long);
  assign addr_x    = {1'b0, acc_addr};
  assign lim_x     = {1'b0, seg_limit};
  assign base_x    = {1'b0, seg_base};
  assign acc_end   = addr_x + EW'(acc_size);
  assign wrapped   = seg_limit < seg_base;

  assign perm_bad  = (acc_write & ~seg_writable) |
                     (~acc_write & ~acc_exec & ~seg_readable);

  always_comb begin
    unique case ({seg_expdown, wrapped})
      2'b00:   lim_bad = lim_x < acc_end;
      2'b01:   lim_bad = (lim_x < acc_end) && (acc_addr < seg_base);
      2'b11:   lim_bad = (acc_addr <= seg_limit) || (acc_end >= base_x);
      default: lim_bad = (acc_addr <= seg_limit) && (acc_end >= base_x);
    endcase
  end

  assign fault_n = checks_on & (perm_bad | lim_bad);
  assign xlate_n = prot_en & paging_en & ~fault_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      gp_fault   <= 1'b0;
      fault_code <= '0;
      xlate_req  <= 1'b0;
      phys_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        gp_fault   <= fault_n;
        fault_code <= '0;
        xlate_req  <= xlate_n;
        phys_addr  <= (fault_n | xlate_n) ? '0 : acc_addr;
      end
    end
  end

  p_strobe_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_strobe_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_real_mode_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !prot_en) |=>
      (!gp_fault && !xlate_req && phys_addr == $past(acc_addr)));
  p_long_mode_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && prot_en && lma && cs_long) |=> !gp_fault);
  p_write_perm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && prot_en && !(lma && cs_long) && acc_write && !seg_writable)
      |=> gp_fault);
  p_fault_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> (!xlate_req && phys_addr == '0 && fault_code == '0));
endmodule

// File: tb/seg_access_check_tb.sv
module seg_access_check_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic        prot_en = 0, paging_en = 0, lma = 0, cs_long = 0;
  logic        seg_writable = 1, seg_readable = 1, seg_expdown = 0;
  logic [31:0] seg_base = 0, seg_limit = 0, acc_addr = 0;
  logic [3:0]  acc_size = 0;
  logic        acc_write = 0, acc_exec = 0;
  logic        out_valid, gp_fault, xlate_req;
  logic [15:0] fault_code;
  logic [31:0] phys_addr;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  seg_access_check dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic seg(logic pe, logic pg, logic wr_ok, logic rd_ok, logic dn,
                     logic [31:0] b, logic [31:0] l);
    prot_en = pe; paging_en = pg; seg_writable = wr_ok; seg_readable = rd_ok;
    seg_expdown = dn; seg_base = b; seg_limit = l; lma = 0; cs_long = 0;
  endtask

  task automatic access(string tag, logic [31:0] a, logic [3:0] sz, logic w,
                        logic x, logic ef, logic ex, logic [31:0] ep);
    @(negedge clk);
    acc_addr = a; acc_size = sz; acc_write = w; acc_exec = x; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk({tag, " valid"}, 32'(out_valid), 1);
    chk({tag, " fault"}, 32'(gp_fault), 32'(ef));
    chk({tag, " xlate"}, 32'(xlate_req), 32'(ex));
    chk({tag, " phys"}, phys_addr, ep);
    chk({tag, " code R11"}, 32'(fault_code), 0);
  endtask

  task automatic t_reset;
    chk("R1 reset valid", 32'(out_valid), 0);
    chk("R1 reset fault", 32'(gp_fault), 0);
    chk("R1 reset phys", phys_addr, 0);
  endtask

  task automatic t_strobe;
    seg(0, 0, 1, 1, 0, 0, 32'hFFFF_FFFF);
    access("R1 strobe", 32'h1234, 1, 0, 0, 0, 0, 32'h1234);
    @(negedge clk);
    chk("R1 valid drops", 32'(out_valid), 0);
    chk("R1 hold phys", phys_addr, 32'h1234);
  endtask

  task automatic t_real;
    seg(0, 1, 0, 0, 0, 32'h9000, 32'h10);
    access("R2 real write", 32'hABCD_0000, 4, 1, 0, 0, 0, 32'hABCD_0000);
    access("R2 real read", 32'h0000_5000, 2, 0, 0, 0, 0, 32'h5000);
  endtask

  task automatic t_long;
    seg(1, 0, 0, 0, 0, 32'h1000, 32'h1001);
    lma = 1; cs_long = 1;
    access("R3 64bit skip", 32'h8000, 4, 1, 0, 0, 0, 32'h8000);
    cs_long = 0;
    access("R3 lma only", 32'h1000, 1, 1, 0, 1, 0, 0);
    lma = 0; cs_long = 1;
    access("R3 cs only", 32'h1000, 1, 1, 0, 1, 0, 0);
  endtask

  task automatic t_perm;
    seg(1, 0, 0, 1, 0, 0, 32'hFFFF);
    access("R4 write ro", 32'h100, 4, 1, 0, 1, 0, 0);
    seg(1, 0, 1, 1, 0, 0, 32'hFFFF);
    access("R4 write rw", 32'h100, 4, 1, 0, 0, 0, 32'h100);
    seg(1, 0, 1, 0, 0, 0, 32'hFFFF);
    access("R5 read unreadable", 32'h200, 4, 0, 0, 1, 0, 0);
    access("R5 exec unreadable", 32'h200, 4, 0, 1, 0, 0, 32'h200);
  endtask

  task automatic t_up;
    seg(1, 0, 1, 1, 0, 32'h1000, 32'h2000);
    access("R6 at limit", 32'h1FFC, 4, 0, 0, 0, 0, 32'h1FFC);
    access("R6 past limit", 32'h1FFD, 4, 0, 0, 1, 0, 0);
    seg(1, 0, 1, 1, 0, 32'h8000, 32'h1000);
    access("R7 gap", 32'h2000, 4, 0, 0, 1, 0, 0);
    access("R7 above base", 32'h9000, 4, 0, 0, 0, 0, 32'h9000);
    access("R7 below limit", 32'h0FF0, 4, 0, 0, 0, 0, 32'h0FF0);
  endtask

  task automatic t_down;
    seg(1, 0, 1, 1, 1, 32'h8000, 32'h1000);
    access("R8 addr at limit", 32'h1000, 1, 0, 0, 1, 0, 0);
    access("R8 inside", 32'h4000, 4, 0, 0, 0, 0, 32'h4000);
    access("R8 end at base", 32'h7FFC, 4, 0, 0, 1, 0, 0);
    seg(1, 0, 1, 1, 1, 32'h1000, 32'h5000);
    access("R9 above limit", 32'h6000, 4, 0, 0, 0, 0, 32'h6000);
    access("R9 below base", 32'h0100, 4, 0, 0, 0, 0, 32'h0100);
    access("R9 inside hole", 32'h3000, 4, 0, 0, 1, 0, 0);
  endtask

  task automatic t_paging;
    seg(1, 1, 1, 1, 0, 0, 32'hFFFF);
    access("R10 translate", 32'h4321, 4, 0, 0, 0, 1, 0);
    access("R11 fault no xlate", 32'h1_0000, 4, 0, 0, 1, 0, 0);
    seg(1, 0, 1, 1, 0, 0, 32'hFFFF);
    access("R10 no paging", 32'h4321, 4, 0, 0, 0, 0, 32'h4321);
  endtask

  task automatic t_carry;
    seg(1, 0, 1, 1, 0, 0, 32'hFFFF_FFFF);
    access("R12 carry out", 32'hFFFF_FFFE, 4, 0, 0, 1, 0, 0);
    access("R12 last byte", 32'hFFFF_FFFE, 1, 0, 0, 0, 0, 32'hFFFF_FFFE);
  endtask

  initial begin
    #1 t_reset;
    #10 rst_n = 1;
    t_strobe; t_real; t_long; t_perm; t_up; t_down; t_paging; t_carry;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule